// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block provides a parameterised number of general-purpose I/O banks, each up to 32 pins wide, behind a simple word-addressed register bus. Every pin has its own control word. The control word sets the pin's direction and picks which input transitions are recorded as interrupt events. Output levels are never written directly. Software pulses a set register or a clear register, and a 1 in a bit position drives that pin high or low. Only pins configured as outputs respond to these strobes.

Each bank keeps a sticky interrupt status. A bit is set by a qualifying edge on the synchronised input and cleared by writing 1 to it. The bank also holds a mask that has separate mask and unmask write ports. Each bank drives one interrupt line, which is high while any status bit has its mask bit clear. An external per-pin lock vector from a protection unit blocks changes to a pin's control word. Pins appear as three separate vectors: input, output level and output enable.

The bus uses a single-cycle write strobe and combinational read data. Reads of write-only locations return zero.

Top module: `edge_gpio_bank`

## Requirements
- R1: After reset, every pin is an input (output enable low), every output level is 0, every status bit is 0, every mask bit is 1 and every bank interrupt is low.
- R2: The control word of pin p is at byte address 0x100 + 4*p. Bit 0 = 1 makes the pin an input and 0 makes it an output, with the output enable following the inverse. Bits [4:3] hold the edge type, and a read returns the word with all other bits zero.
- R3: A write to 0x40 + 4*bank drives high every output-configured pin whose data bit is 1. A write to 0x60 + 4*bank drives such pins low. Zero bits leave pins unchanged, and 0x00 + 4*bank reads back the output levels.
- R4: Set and clear writes leave the output level of input-configured pins unchanged.
- R5: Address 0x20 + 4*bank reads the pin inputs after a two-flop synchroniser, so a change becomes visible at the second rising clock edge after it.
- R6: Edge type 1 records rising edges, 2 falling edges, 3 both edges and 0 none. A recorded event sets the pin's bit in the status register at 0x80 + 4*bank, and the bit stays set.
- R7: Writing 1 to a bit at 0x80 + 4*bank clears that status bit. Zero bits have no effect.
- R8: Writing 1 at 0xA0 + 4*bank masks that pin, and writing 1 at 0xC0 + 4*bank unmasks it. 0xA0 + 4*bank reads the mask.
- R9: Each bank interrupt line is high exactly while some status bit of that bank is set with its mask bit clear.
- R10: When an edge event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R11: A control-word write to a pin whose lock input is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 11 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_BANKS*PINS_PER_BANK | Pin input levels (asynchronous) |
| pin_lock | input | NUM_BANKS*PINS_PER_BANK | Per-pin configuration lock |
| pin_out | output | NUM_BANKS*PINS_PER_BANK | Output levels |
| pin_oe | output | NUM_BANKS*PINS_PER_BANK | Output enables |
| bank_irq | output | NUM_BANKS | Per-bank interrupt |

## Verification
A corrupted status or mask bit shows on bank_irq in the same cycle as the fault, and on a status read at once. A lost edge event shows in the status readback two cycles after the synchroniser delivers the change. A wrong direction or lock decision shows on pin_oe the cycle after the control write. A set or clear strobe applied to an input pin shows on pin_out one cycle after the write. The same-cycle race between an edge and a clear is timed exactly, so a design where the clear wins leaves a zero where a one is expected.

// File: rtl/egb_pkg.sv
package egb_pkg;
   localparam int BUS_W          = 32;
   localparam int ADDR_W         = 11;
   localparam int WORD_W         = ADDR_W - 2;
   localparam int MAX_BANKS      = 8;
   localparam int CTRL_BASE_WORD = 64;

   typedef enum logic [2:0] {
      RK_OUT_STATE = 3'd0,
      RK_IN_STATE  = 3'd1,
      RK_OUT_SET   = 3'd2,
      RK_OUT_CLR   = 3'd3,
      RK_IRQ_STATE = 3'd4,
      RK_MASK_SET  = 3'd5,
      RK_MASK_CLR  = 3'd6,
      RK_NONE      = 3'd7
   } bank_reg_e;

   typedef enum logic [1:0] {
      TRIG_OFF  = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_BOTH = 2'd3
   } trig_e;
endpackage

// File: rtl/egb_sync.sv
module egb_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("egb_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/egb_pin_cfg.sv
module egb_pin_cfg
   import egb_pkg::*;
#(
   parameter int NUM_PINS = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic [WORD_W-1:0]     cfg_word,
   input  logic                  dir_bit,
   input  trig_e                 trig_in,
   input  logic [NUM_PINS-1:0]   lock,
   output logic [NUM_PINS-1:0]   is_input,
   output logic [2*NUM_PINS-1:0] trig_flat
);
   generate
      if (CTRL_BASE_WORD + NUM_PINS > (1 << WORD_W)) begin : g_bad_span
         $error("pin control words exceed the address space");
      end
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic  hit;
         logic  dir_q;
         trig_e trig_q;
         assign hit = cfg_wr && !lock[p] && (cfg_word == WORD_W'(CTRL_BASE_WORD + p));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dir_q  <= 1'b1;
               trig_q <= TRIG_OFF;
            end else if (hit) begin
               dir_q  <= dir_bit;
               trig_q <= trig_in;
            end
         end
         assign is_input[p]        = dir_q;
         assign trig_flat[2*p +: 2] = trig_q;
      end
   endgenerate
endmodule

// File: rtl/egb_bank.sv
module egb_bank
   import egb_pkg::*;
#(
   parameter int PPB = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PPB-1:0]   sync_in,
   input  logic [PPB-1:0]   is_input,
   input  logic [2*PPB-1:0] trig_flat,
   input  logic [PPB-1:0]   wdata,
   input  logic             stb_set,
   input  logic             stb_clr,
   input  logic             stb_ack,
   input  logic             stb_msk,
   input  logic             stb_umsk,
   output logic [PPB-1:0]   drv,
   output logic [PPB-1:0]   stat,
   output logic [PPB-1:0]   mask,
   output logic             irq
);
   logic [PPB-1:0] prev_q;
   logic [PPB-1:0] rise, fall, ev;
   logic [PPB-1:0] outable;

   assign rise    = sync_in & ~prev_q;
   assign fall    = ~sync_in & prev_q;
   assign outable = ~is_input;

   generate
      for (genvar i = 0; i < PPB; i++) begin : g_det
         trig_e t;
         assign t = trig_e'(trig_flat[2*i +: 2]);
         assign ev[i] = ((t == TRIG_RISE) && rise[i]) ||
                        ((t == TRIG_FALL) && fall[i]) ||
                        ((t == TRIG_BOTH) && (rise[i] || fall[i]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         drv    <= '0;
         stat   <= '0;
         mask   <= '1;
      end else begin
         prev_q <= sync_in;
         if (stb_set) drv <= drv | (wdata & outable);
         else if (stb_clr) drv <= drv & ~(wdata & outable);
         // an edge in the same cycle overrides the clear
         stat <= (stat & ~(stb_ack ? wdata : '0)) | ev;
         if (stb_msk) mask <= mask | wdata;
         else if (stb_umsk) mask <= mask & ~wdata;
      end
   end

   assign irq = |(stat & ~mask);
endmodule

// File: rtl/edge_gpio_bank.sv
module edge_gpio_bank
   import egb_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int PINS_PER_BANK = 32,
   parameter int SYNC_STAGES   = 2,
   localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [NUM_PINS-1:0]  pin_in,
   input  logic [NUM_PINS-1:0]  pin_lock,
   output logic [NUM_PINS-1:0]  pin_out,
   output logic [NUM_PINS-1:0]  pin_oe,
   output logic [NUM_BANKS-1:0] bank_irq
);
   localparam int PPB = PINS_PER_BANK;

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > MAX_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must lie in 1..8");
      end
      if (PPB < 1 || PPB > BUS_W) begin : g_bad_width
         $error("PINS_PER_BANK must lie in 1..32");
      end
   endgenerate

   logic [WORD_W-1:0]   word;
   logic                aligned;
   logic                bank_zone;
   bank_reg_e           kind;
   logic [2:0]          bank_sel;
   logic [NUM_PINS-1:0] sync_in;
   logic [NUM_PINS-1:0] is_input;
   logic [2*NUM_PINS-1:0] trig_flat;
   logic [NUM_PINS-1:0] stat_all;
   logic [NUM_PINS-1:0] mask_all;
   logic [BUS_W*NUM_BANKS-1:0] rd_flat;

   assign word      = bus_addr[ADDR_W-1:2];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign bank_zone = (word < WORD_W'(CTRL_BASE_WORD));
   assign kind      = bank_reg_e'(word[5:3]);
   assign bank_sel  = word[2:0];

   egb_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (sync_in)
   );

   egb_pin_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (bus_wr && aligned && !bank_zone),
      .cfg_word  (word),
      .dir_bit   (bus_wdata[0]),
      .trig_in   (trig_e'(bus_wdata[4:3])),
      .lock      (pin_lock),
      .is_input  (is_input),
      .trig_flat (trig_flat)
   );

   assign pin_oe = ~is_input;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic hit;
         logic [PPB-1:0] drv, stat, mask;
         logic [BUS_W-1:0] rd;
         assign hit = bus_wr && aligned && bank_zone && (bank_sel == 3'(b));

         egb_bank #(.PPB(PPB)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .sync_in   (sync_in[b*PPB +: PPB]),
            .is_input  (is_input[b*PPB +: PPB]),
            .trig_flat (trig_flat[2*PPB*b +: 2*PPB]),
            .wdata     (bus_wdata[PPB-1:0]),
            .stb_set   (hit && kind == RK_OUT_SET),
            .stb_clr   (hit && kind == RK_OUT_CLR),
            .stb_ack   (hit && kind == RK_IRQ_STATE),
            .stb_msk   (hit && kind == RK_MASK_SET),
            .stb_umsk  (hit && kind == RK_MASK_CLR),
            .drv       (drv),
            .stat      (stat),
            .mask      (mask),
            .irq       (bank_irq[b])
         );

         assign pin_out[b*PPB +: PPB]  = drv;
         assign stat_all[b*PPB +: PPB] = stat;
         assign mask_all[b*PPB +: PPB] = mask;

         always_comb begin
            rd = '0;
            case (kind)
               RK_OUT_STATE: rd[PPB-1:0] = drv;
               RK_IN_STATE:  rd[PPB-1:0] = sync_in[b*PPB +: PPB];
               RK_IRQ_STATE: rd[PPB-1:0] = stat;
               RK_MASK_SET:  rd[PPB-1:0] = mask;
               default:      rd = '0;
            endcase
         end
         assign rd_flat[BUS_W*b +: BUS_W] = rd;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (bank_zone) begin
            for (int b = 0; b < NUM_BANKS; b++)
               if (bank_sel == 3'(b)) bus_rdata = rd_flat[BUS_W*b +: BUS_W];
         end else begin
            for (int p = 0; p < NUM_PINS; p++)
               if (word == WORD_W'(CTRL_BASE_WORD + p))
                  bus_rdata = {{(BUS_W-5){1'b0}}, trig_flat[2*p +: 2], 2'b00, is_input[p]};
         end
      end
   end
endmodule

// File: rtl/egb_checker.sv
module egb_checker
   import egb_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int PINS_PER_BANK = 32,
   localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK,
   localparam int P            = PINS_PER_BANK
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [BUS_W-1:0]     bus_wdata,
   input logic [NUM_PINS-1:0]  pin_lock,
   input logic [NUM_PINS-1:0]  pin_out,
   input logic [NUM_PINS-1:0]  pin_oe,
   input logic [NUM_BANKS-1:0] bank_irq,
   input logic [P-1:0]         st0
);
   localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(32'h40);
   localparam logic [ADDR_W-1:0] A_ACK0  = ADDR_W'(32'h80);
   localparam logic [ADDR_W-1:0] A_MSK0  = ADDR_W'(32'hA0);
   localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(32'h100);

   logic          set0_wr;
   logic [P-1:0]  keep;
   assign set0_wr = bus_wr && (bus_addr == A_SET0);
   assign keep = st0 & ~((bus_wr && bus_addr == A_ACK0) ? bus_wdata[P-1:0] : '0);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (bank_irq == '0 && pin_oe == '0 && pin_out == '0));

   assert_set_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set0_wr |=> ((pin_out[P-1:0] & $past(bus_wdata[P-1:0] & pin_oe[P-1:0]))
                   == $past(bus_wdata[P-1:0] & pin_oe[P-1:0])));

   assert_input_pin_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set0_wr |=> ((pin_out[P-1:0] & ~$past(pin_oe[P-1:0]))
                   == ($past(pin_out[P-1:0]) & ~$past(pin_oe[P-1:0]))));

   assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|keep) |=> ((st0 & $past(keep)) == $past(keep)));

   assert_full_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_MSK0 && bus_wdata[P-1:0] == {P{1'b1}}) |=> !bank_irq[0]);

   assert_locked_cfg_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CTRL0 && pin_lock[0]) |=> $stable(pin_oe[0]));
endmodule

bind edge_gpio_bank egb_checker #(
   .NUM_BANKS     (NUM_BANKS),
   .PINS_PER_BANK (PINS_PER_BANK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_lock  (pin_lock),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .bank_irq  (bank_irq),
   .st0       (stat_all[PINS_PER_BANK-1:0])
);

// File: tb/edge_gpio_bank_test.sv
`timescale 1ns/1ps
module edge_gpio_bank_test;
   localparam int NB = 2;
   localparam int NP = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [10:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_lock = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic [NB-1:0] bank_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   logic [NP-1:0] m_out, m_dir, m_stat, m_mask;
   logic [1:0]    m_trig [NP];

   always #2.5 clk = ~clk;

   edge_gpio_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_lock(pin_lock), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [10:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic exp_irq(input int b);
      return |(m_stat[b*32 +: 32] & ~m_mask[b*32 +: 32]);
   endfunction

   function automatic logic [31:0] exp_ctrl(input int p);
      return {27'b0, m_trig[p], 2'b00, m_dir[p]};
   endfunction

   task automatic do_cfg(input int p, input logic dir, input logic [1:0] tr);
      wr(11'(32'h100 + 4*p), {27'b0, tr, 2'b00, dir});
      if (!pin_lock[p]) begin m_dir[p] = dir; m_trig[p] = tr; end
   endtask

   task automatic do_set(input int b, input logic [31:0] d);
      wr(11'(32'h40 + 4*b), d);
      m_out[b*32 +: 32] = m_out[b*32 +: 32] | (d & ~m_dir[b*32 +: 32]);
   endtask

   task automatic do_clr(input int b, input logic [31:0] d);
      wr(11'(32'h60 + 4*b), d);
      m_out[b*32 +: 32] = m_out[b*32 +: 32] & ~(d & ~m_dir[b*32 +: 32]);
   endtask

   task automatic do_ack(input int b, input logic [31:0] d);
      wr(11'(32'h80 + 4*b), d);
      m_stat[b*32 +: 32] = m_stat[b*32 +: 32] & ~d;
   endtask

   task automatic do_msk(input int b, input logic [31:0] d);
      wr(11'(32'hA0 + 4*b), d);
      m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
   endtask

   task automatic do_umsk(input int b, input logic [31:0] d);
      wr(11'(32'hC0 + 4*b), d);
      m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
   endtask

   task automatic drive_pins(input logic [NP-1:0] nv);
      @(negedge clk);
      for (int i = 0; i < NP; i++) begin
         logic r, f;
         r = !pin_in[i] && nv[i];
         f = pin_in[i] && !nv[i];
         if ((m_trig[i] == 2'd1 && r) || (m_trig[i] == 2'd2 && f) ||
             (m_trig[i] == 2'd3 && (r || f)))
            m_stat[i] = 1'b1;
      end
      pin_in = nv;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_all();
      logic [31:0] d;
      for (int b = 0; b < NB; b++) begin
         rd(11'(4*b), d);            chk("R3 out state", d, m_out[b*32 +: 32]);
         rd(11'(32'h20 + 4*b), d);   chk("R5 in state", d, pin_in[b*32 +: 32]);
         rd(11'(32'h80 + 4*b), d);   chk("R6 irq status", d, m_stat[b*32 +: 32]);
         rd(11'(32'hA0 + 4*b), d);   chk("R8 mask", d, m_mask[b*32 +: 32]);
         chk("R9 bank irq", bank_irq[b], exp_irq(b));
      end
      chk("R3 pin_out", pin_out, m_out);
      chk("R2 pin_oe", pin_oe, ~m_dir);
      begin
         int p;
         p = int'($urandom % NP);
         rd(11'(32'h100 + 4*p), d);
         chk("R2 ctrl readback", d, exp_ctrl(p));
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd4242));
      m_out = '0; m_dir = '1; m_stat = '0; m_mask = '1;
      for (int i = 0; i < NP; i++) m_trig[i] = 2'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(11'h0A0, d); chk("R1 mask after reset", d, 32'hFFFF_FFFF);
      rd(11'h0A4, d); chk("R1 mask bank1 after reset", d, 32'hFFFF_FFFF);
      rd(11'h080, d); chk("R1 status after reset", d, 32'h0);
      chk("R1 irq after reset", bank_irq, 2'b00);
      chk("R1 oe after reset", pin_oe, 64'h0);
      chk("R1 out after reset", pin_out, 64'h0);
      rd(11'h114, d); chk("R1 ctrl pin5 after reset", d, 32'h1);

      // R5 synchroniser latency (pin 20 has edge type 0)
      @(negedge clk);
      pin_in[20] = 1'b1;
      @(negedge clk);
      rd(11'h020, d); chk("R5 one edge later still old", d, 32'h0);
      @(negedge clk);
      rd(11'h020, d); chk("R5 two edges later new", d, 32'h0010_0000);
      repeat (3) @(negedge clk);
      rd(11'h080, d); chk("R6 type 0 records nothing", d, 32'h0);

      // R6 edge types
      do_cfg(8, 1'b1, 2'd1);
      do_cfg(9, 1'b1, 2'd2);
      do_cfg(10, 1'b1, 2'd3);
      do_cfg(11, 1'b1, 2'd0);
      drive_pins(pin_in | 64'h0F00);
      rd(11'h080, d); chk("R6 rising edges", d, 32'h0000_0500);
      drive_pins(pin_in & ~64'h0F00);
      rd(11'h080, d); chk("R6 falling edges, sticky", d, 32'h0000_0700);

      // R7 write-one-to-clear
      do_ack(0, 32'h0000_0100);
      rd(11'h080, d); chk("R7 clear bit 8 only", d, 32'h0000_0600);

      // R8 / R9 mask and irq
      chk("R9 masked irq low", bank_irq, 2'b00);
      do_umsk(0, 32'h0000_0200);
      rd(11'h0A0, d); chk("R8 unmask bit 9", d, 32'hFFFF_FDFF);
      chk("R9 irq with unmasked status", bank_irq, 2'b01);
      do_msk(0, 32'h0000_0200);
      chk("R8 re-mask drops irq", bank_irq, 2'b00);

      // R10 edge and clear in the same cycle (pin 10, both edges, bit set)
      @(negedge clk);
      pin_in[10] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 11'h080; bus_wdata = 32'h0000_0400;
      @(negedge clk);
      bus_wr = 1'b0;
      repeat (3) @(negedge clk);
      rd(11'h080, d); chk("R10 edge beats clear", d, 32'h0000_0600);
      do_ack(0, 32'h0000_0400);
      rd(11'h080, d); chk("R7 plain clear", d, 32'h0000_0200);

      // R11 locked pin
      pin_lock[12] = 1'b1;
      do_cfg(12, 1'b0, 2'd3);
      chk("R11 locked pin stays input", pin_oe[12], 1'b0);
      rd(11'h130, d); chk("R11 locked ctrl unchanged", d, 32'h1);
      pin_lock[12] = 1'b0;
      do_cfg(12, 1'b0, 2'd0);
      chk("R2 output enable", pin_oe[12], 1'b1);
      rd(11'h130, d); chk("R2 ctrl output readback", d, 32'h0);

      // R3 / R4 set and clear
      do_set(0, 32'h0000_3000);
      chk("R3 set output pin", pin_out[12], 1'b1);
      chk("R4 set ignored on input pin", pin_out[13], 1'b0);
      do_clr(0, 32'h0000_1000);
      chk("R3 clear output pin", pin_out[12], 1'b0);
      check_all();

      // constrained random mix
      for (int it = 0; it < 300; it++) begin
         int op, b;
         op = int'($urandom % 8);
         b  = int'($urandom % NB);
         case (op)
            0: do_cfg(int'($urandom % NP), 1'($urandom), 2'($urandom));
            1: do_set(b, $urandom);
            2: do_clr(b, $urandom);
            3: do_ack(b, $urandom);
            4: do_msk(b, $urandom & $urandom);
            5: do_umsk(b, $urandom & $urandom);
            6: drive_pins({$urandom, $urandom});
            default: begin
               pin_lock = {$urandom, $urandom} & {$urandom, $urandom};
               do_cfg(int'($urandom % NP), 1'($urandom), 2'($urandom));
            end
         endcase
         if (it % 4 == 3) check_all();
      end
      check_all();

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule